// File: doc/BRIEF.md
# Partial-Width Register File Writer

This block is a general-purpose register file with sixteen 64-bit entries, two read ports and one write port. Each write carries an operand size of 1, 2, 4 or 8 bytes. The size decides what happens to the bytes above the written portion. For 1- and 2-byte writes those bytes keep their old contents. A 4-byte write clears the upper half. An 8-byte write replaces the whole entry.

An extend stage sits in front of the write merge. It can widen a narrow source value to the wider destination size, filling with zeros or with copies of the source's top bit. Each read port returns the low 1, 2, 4 or 8 bytes of any entry, padded with zeros to 64 bits. An execution pipeline uses the block as its integer register state: narrow loads, moves and widening conversions all end in a single write here.

Top module: `gpr_merge_file`

## Requirements
- R1: While `rst_ni` is low all sixteen entries are cleared to zero, and after reset every entry reads as zero.
- R2: A write with size code 0 (1 byte) updates bits 7:0 of the addressed entry and leaves bits 63:8 unchanged.
- R3: A write with size code 1 (2 bytes) updates bits 15:0 and leaves bits 63:16 unchanged.
- R4: A write with size code 2 (4 bytes) stores bits 31:0 and forces bits 63:32 to zero.
- R5: A write with size code 3 (8 bytes) replaces all 64 bits.
- R6: With extend code 1 (zero fill) and a source size code below the destination size code, the bytes between the source width and the destination width are written as zero. The destination size rule of R2 to R5 then applies.
- R7: With extend code 2 (sign fill) and a source size code below the destination size code, those bytes are written as copies of bit (8·2^src)−1 of the write data.
- R8: Reading an entry at 4 bytes and writing the value back to the same entry with sign fill, source code 2 and destination code 3, leaves the 64-bit sign extension of its low word in the entry.
- R9: A zero-fill request from source code 2 to destination code 3 acts as a 4-byte write: the low word is stored and the upper word is cleared.
- R10: An extend request whose source size code is not below the destination size code, or extend code 3, is ignored. The write behaves as a plain write of the destination size.
- R11: Each read port returns the low 2^size bytes of the addressed entry, with the bits above that width driven to zero. The two ports operate independently.
- R12: A read of the entry being written in the same cycle returns the value held before the clock edge. The new value is visible after the edge.
- R13: With `wr_en_i` low, no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 4 | Destination entry |
| wr_data_i | input | 64 | Write source value |
| wr_size_i | input | 2 | Destination size code (0:1B, 1:2B, 2:4B, 3:8B) |
| wr_ext_i | input | 2 | Extend code (0 none, 1 zero fill, 2 sign fill, 3 none) |
| wr_src_size_i | input | 2 | Source size code used when extending |
| rd0_addr_i | input | 4 | Read port 0 entry |
| rd0_size_i | input | 2 | Read port 0 size code |
| rd0_data_o | output | 64 | Read port 0 data, zero padded |
| rd1_addr_i | input | 4 | Read port 1 entry |
| rd1_size_i | input | 2 | Read port 1 size code |
| rd1_data_o | output | 64 | Read port 1 data, zero padded |

## Verification
The bench builds the block with its default parameters: sixteen 64-bit entries and two read ports. With these values every entry can be swept in the reset check, and all four size codes apply at full 64-bit width. Entries are preloaded with all-ones or mixed patterns so that kept, cleared and filled bytes differ visibly. Each pairing of source and destination size is reachable, including the 4-to-8 zero-fill case and the degenerate extend requests.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int XLEN = 64;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} opsz_e;
  typedef enum logic [1:0] {EXT_NONE = 2'd0, EXT_ZERO = 2'd1, EXT_SIGN = 2'd2, EXT_RSVD = 2'd3} ext_e;

  function automatic logic [XLEN-1:0] low_mask(opsz_e s);
    case (s)
      SZ_B:    low_mask = {{(XLEN-8){1'b0}},  {8{1'b1}}};
      SZ_H:    low_mask = {{(XLEN-16){1'b0}}, {16{1'b1}}};
      SZ_W:    low_mask = {{(XLEN-32){1'b0}}, {32{1'b1}}};
      default: low_mask = {XLEN{1'b1}};
    endcase
  endfunction
endpackage

// File: rtl/gpr_extend.sv
module gpr_extend
  import gpr_pkg::*;
(
  input  logic [XLEN-1:0] data_i,
  input  opsz_e           src_i,
  input  opsz_e           dst_i,
  input  ext_e            mode_i,
  output logic [XLEN-1:0] val_o,
  output opsz_e           size_o
);
  logic narrow, sign_bit;
  logic [XLEN-1:0] m;

  assign narrow = src_i < dst_i;
  assign m      = low_mask(src_i);

  always_comb begin
    case (src_i)
      SZ_B:    sign_bit = data_i[7];
      SZ_H:    sign_bit = data_i[15];
      SZ_W:    sign_bit = data_i[31];
      default: sign_bit = data_i[XLEN-1];
    endcase
  end

  always_comb begin
    val_o  = data_i;
    size_o = dst_i;
    if (narrow && mode_i == EXT_ZERO && src_i == SZ_W && dst_i == SZ_D) begin
      // 4->8 zero fill collapses into a plain 4-byte write
      size_o = SZ_W;
    end else if (narrow && (mode_i == EXT_ZERO || mode_i == EXT_SIGN)) begin
      val_o = (data_i & m) | ((mode_i == EXT_SIGN && sign_bit) ? ~m : '0);
    end
  end
endmodule

// File: rtl/gpr_merge.sv
module gpr_merge
  import gpr_pkg::*;
(
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] val_i,
  input  opsz_e           size_i,
  output logic [XLEN-1:0] new_o
);
  always_comb begin
    case (size_i)
      SZ_B:    new_o = {old_i[XLEN-1:8],  val_i[7:0]};
      SZ_H:    new_o = {old_i[XLEN-1:16], val_i[15:0]};
      SZ_W:    new_o = {{(XLEN-32){1'b0}}, val_i[31:0]};
      default: new_o = val_i;
    endcase
  end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_pkg::*;
(
  input  logic [XLEN-1:0] word_i,
  input  opsz_e           size_i,
  output logic [XLEN-1:0] data_o
);
  assign data_o = word_i & low_mask(size_i);
endmodule

// File: rtl/gpr_merge_file.sv
module gpr_merge_file
  import gpr_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int NUM_RD   = 2,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic [1:0]      wr_size_i,
  input  logic [1:0]      wr_ext_i,
  input  logic [1:0]      wr_src_size_i,
  input  logic [AW-1:0]   rd0_addr_i,
  input  logic [1:0]      rd0_size_i,
  output logic [XLEN-1:0] rd0_data_o,
  input  logic [AW-1:0]   rd1_addr_i,
  input  logic [1:0]      rd1_size_i,
  output logic [XLEN-1:0] rd1_data_o
);
  logic [XLEN-1:0] regs_q [NUM_REGS];
  logic [XLEN-1:0] ext_val, wr_old, wr_new;
  opsz_e           eff_size;

  gpr_extend u_ext (
    .data_i (wr_data_i),
    .src_i  (opsz_e'(wr_src_size_i)),
    .dst_i  (opsz_e'(wr_size_i)),
    .mode_i (ext_e'(wr_ext_i)),
    .val_o  (ext_val),
    .size_o (eff_size)
  );

  assign wr_old = regs_q[wr_addr_i];

  gpr_merge u_merge (
    .old_i  (wr_old),
    .val_i  (ext_val),
    .size_i (eff_size),
    .new_o  (wr_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (wr_en_i) begin
      regs_q[wr_addr_i] <= wr_new;
    end
  end

  logic [AW-1:0]   rd_addr [NUM_RD];
  logic [1:0]      rd_size [NUM_RD];
  logic [XLEN-1:0] rd_data [NUM_RD];

  assign rd_addr[0] = rd0_addr_i;
  assign rd_size[0] = rd0_size_i;
  assign rd_addr[1] = rd1_addr_i;
  assign rd_size[1] = rd1_size_i;
  assign rd0_data_o = rd_data[0];
  assign rd1_data_o = rd_data[1];

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    gpr_read_port u_rd (
      .word_i (regs_q[rd_addr[p]]),
      .size_i (opsz_e'(rd_size[p])),
      .data_o (rd_data[p])
    );

    assert_rd_pad_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_size[p] != 2'd3) |-> ((rd_data[p] & ~low_mask(opsz_e'(rd_size[p]))) == '0));
  end

  assert_byte_keep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_size_i == 2'd0)
      |=> regs_q[$past(wr_addr_i)][XLEN-1:8] == $past(wr_old[XLEN-1:8]));

  assert_half_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_size_i == 2'd1)
      |=> regs_q[$past(wr_addr_i)][XLEN-1:16] == $past(wr_old[XLEN-1:16]));

  assert_word_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_size_i == 2'd2)
      |=> regs_q[$past(wr_addr_i)][XLEN-1:32] == '0);

  assert_dword_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_size_i == 2'd3 && wr_ext_i == 2'd0)
      |=> regs_q[$past(wr_addr_i)] == $past(wr_data_i));

  assert_sign_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ext_i == 2'd2 && wr_src_size_i < wr_size_i)
      |-> ($countones(ext_val & ~low_mask(opsz_e'(wr_src_size_i))) == 0 ||
           $countones(~(ext_val | low_mask(opsz_e'(wr_src_size_i)))) == 0));

  assert_zero_wide_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_ext_i == 2'd1 && wr_src_size_i == 2'd2 && wr_size_i == 2'd3)
      |=> regs_q[$past(wr_addr_i)] == {32'h0, $past(wr_data_i[31:0])});
endmodule

// File: tb/gpr_merge_file_tb.sv
`timescale 1ns/1ps
module gpr_merge_file_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [1:0]  wr_size = '0, wr_ext = '0, wr_src = '0;
  logic [3:0]  rd0_addr = '0, rd1_addr = '0;
  logic [1:0]  rd0_size = 2'd3, rd1_size = 2'd3;
  logic [63:0] rd0_data, rd1_data;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  gpr_merge_file u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_size_i(wr_size), .wr_ext_i(wr_ext),
    .wr_src_size_i(wr_src), .rd0_addr_i(rd0_addr), .rd0_size_i(rd0_size),
    .rd0_data_o(rd0_data), .rd1_addr_i(rd1_addr), .rd1_size_i(rd1_size),
    .rd1_data_o(rd1_data)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected entry after a write, built byte by byte from the requirements
  function automatic logic [63:0] model(logic [63:0] old, logic [63:0] d,
                                        int sz, int ext, int src);
    int dn = 1 << sz;
    int sn = 1 << src;
    logic [63:0] v = d;
    logic [63:0] r = old;
    if ((ext == 1 || ext == 2) && src < sz) begin
      if (ext == 1 && src == 2 && sz == 3) dn = 4;
      else for (int b = sn; b < 8; b++)
        v[b*8 +: 8] = (ext == 2 && d[sn*8-1]) ? 8'hFF : 8'h00;
    end
    for (int b = 0; b < dn; b++) r[b*8 +: 8] = v[b*8 +: 8];
    if (dn == 4) r[63:32] = '0;
    return r;
  endfunction

  task automatic wr(int a, logic [63:0] d, int sz, int ext = 0, int src = 0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    wr_size = 2'(sz); wr_ext = 2'(ext); wr_src = 2'(src);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, int sz, output logic [63:0] q);
    rd0_addr = 4'(a); rd0_size = 2'(sz);
    #1 q = rd0_data;
  endtask

  task automatic t_reset;
    logic [63:0] q;
    for (int i = 0; i < 16; i++) begin
      rd1_addr = 4'(i); rd1_size = 2'd3;
      rd(i, 3, q);
      check("R1 port0", q, 64'h0);
      check("R1 port1", rd1_data, 64'h0);
    end
  endtask

  task automatic t_sizes;
    logic [63:0] q, e;
    wr(3, 64'h1122334455667788, 3);
    rd(3, 3, q); check("R5 full write", q, 64'h1122334455667788);
    e = model(64'h1122334455667788, 64'hFFFF_FFFF_FFFF_FFAB, 0, 0, 0);
    wr(3, 64'hFFFF_FFFF_FFFF_FFAB, 0);
    rd(3, 3, q); check("R2 byte keep", q, e);
    wr(3, 64'hEEEE_EEEE_EEEE_BEEF, 1);
    rd(3, 3, q); check("R3 half keep", q, 64'h112233445566BEEF);
    wr(3, 64'hFFFF_FFFF_CAFE_F00D, 2);
    rd(3, 3, q); check("R4 word clear", q, 64'h00000000CAFEF00D);
  endtask

  task automatic t_zext;
    logic [63:0] q;
    wr(4, '1, 3);
    wr(4, 64'h1234_5678_9ABC_DEF0, 1, 1, 0);
    rd(4, 3, q); check("R6 zero B->H", q, 64'hFFFFFFFFFFFF00F0);
    wr(4, 64'h1234_5678_9ABC_DEF0, 3, 1, 1);
    rd(4, 3, q); check("R6 zero H->D", q, 64'h000000000000DEF0);
  endtask

  task automatic t_sext;
    logic [63:0] q;
    wr(5, '1, 3);
    wr(5, 64'h0000_0000_0000_009C, 1, 2, 0);
    rd(5, 3, q); check("R7 sign B->H", q, 64'hFFFFFFFFFFFFFF9C);
    wr(5, 64'h0, 3);
    wr(5, 64'hAAAA_AAAA_AAAA_0080, 3, 2, 0);
    rd(5, 3, q); check("R7 sign B->D neg", q, 64'hFFFFFFFFFFFFFF80);
    wr(5, 64'hFFFF_FFFF_FFFF_7FFF, 2, 2, 1);
    rd(5, 3, q); check("R7 sign H->W pos", q, 64'h0000000000007FFF);
  endtask

  task automatic t_same_reg_sext;
    logic [63:0] q, w;
    wr(6, 64'hDEADBEEF87654321, 3);
    rd(6, 2, w);
    check("R8 word read", w, 64'h0000000087654321);
    wr(6, w, 3, 2, 2);
    rd(6, 3, q); check("R8 sign W->D same reg", q, 64'hFFFFFFFF87654321);
  endtask

  task automatic t_zext_wide;
    logic [63:0] q;
    wr(8, '1, 3);
    wr(8, 64'hAAAA5555CAFEF00D, 3, 1, 2);
    rd(8, 3, q); check("R9 zero W->D", q, 64'h00000000CAFEF00D);
  endtask

  task automatic t_bad_ext;
    logic [63:0] q;
    wr(9, 64'h0123456789ABCDEF, 3);
    wr(9, 64'h0000_0000_0000_0080, 0, 2, 3);
    rd(9, 3, q); check("R10 src wider ignored", q, 64'h0123456789ABCD80);
    wr(9, 64'h0000_0000_0000_8001, 1, 2, 1);
    rd(9, 3, q); check("R10 src equal ignored", q, 64'h0123456789AB8001);
    wr(9, 64'h0000_0000_0000_8001, 3, 3, 1);
    rd(9, 3, q); check("R10 ext code 3 plain", q, 64'h0000000000008001);
  endtask

  task automatic t_read;
    logic [63:0] q;
    wr(7, 64'h8877665544332211, 3);
    rd1_addr = 4'd7;
    rd1_size = 2'd1;
    rd(7, 0, q);
    check("R11 port0 byte", q, 64'h11);
    check("R11 port1 half", rd1_data, 64'h2211);
    rd1_size = 2'd2;
    rd(7, 3, q);
    check("R11 port0 full", q, 64'h8877665544332211);
    check("R11 port1 word", rd1_data, 64'h44332211);
  endtask

  task automatic t_same_cycle;
    logic [63:0] q;
    wr(10, 64'h1111111111111111, 3);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd10; wr_data = 64'h2222222222222222;
    wr_size = 2'd3; wr_ext = 2'd0; wr_src = 2'd0;
    rd(10, 3, q); check("R12 old before edge", q, 64'h1111111111111111);
    @(negedge clk);
    wr_en = 1'b0;
    rd(10, 3, q); check("R12 new after edge", q, 64'h2222222222222222);
  endtask

  task automatic t_idle;
    logic [63:0] q;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 4'd10; wr_data = 64'h5A5A5A5A5A5A5A5A; wr_size = 2'd3;
    @(negedge clk);
    @(negedge clk);
    rd(10, 3, q); check("R13 disabled write", q, 64'h2222222222222222);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sizes();
    t_zext();
    t_sext();
    t_same_reg_sext();
    t_zext_wide();
    t_bad_ext();
    t_read();
    t_same_cycle();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule